// File: doc/BRIEF.md
# Masked Bus Watchpoint Comparator

This block watches every cycle of a processor bus and flags a hit when the cycle's address, data and control attributes agree with values that have been programmed into it. Each of the three compared fields (address, data, control) has a value register and a mask register of the same shape. A mask bit set to 1 removes that bit position from the comparison. With a mask bit of 0, the bus bit has to equal the programmed bit. A separate enable bit in the control value register turns the unit on. That bit has no mask.

The control field covers the transfer direction, transfer size, fetch or data access, privilege, an external debug input and a chain input from a neighbouring unit. A reserved linking bit is always compared against 0. Software programs the six registers through a small write port that has a 3-bit register select. The unit produces a registered match pulse one cycle after each qualifying bus cycle. It also produces a same-cycle chain output that a second unit can take on its chain input.

Top module: `bus_watchpoint`

## Requirements
- R1: A mask bit of 1 in any mask register makes its bit position match, whatever the value register and the bus input hold.
- R2: A bit position whose mask bit is 0 matches only when the bus input bit equals the programmed value bit. One mismatching unmasked bit in any field suppresses the match.
- R3: With the data mask at all ones, the data bus has no influence, so the unit acts as an address-only watchpoint.
- R4: The control compare layout is: bit0 direction (1 = write), bits 2:1 size (00 byte, 01 halfword, 10 word, 11 reserved), bit3 access kind (0 = instruction fetch, 1 = data), bit4 privilege (0 = user, 1 = non-user), bit5 against `dbg_ext`, bit6 against `chain_in`, and bit7 against constant 0.
- R5: Bit 8 of the control value register is the enable bit. When it is 0, no match is produced. The control mask holds only bits 7:0, so bit 8 of a control mask write does not affect the enable.
- R6: `match_out` is high for exactly the one cycle after each bus cycle that has `bus_valid` high and matches. Back-to-back matching cycles give back-to-back pulses. A cycle with `bus_valid` low never matches.
- R7: `chain_out` is the unregistered match of the current bus cycle, qualified by `bus_valid` and enable.
- R8: Register select codes: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value (bits 8:0), 5 control mask (bits 7:0). Writes with codes 6 and 7 change no register.
- R9: After reset, all value and mask registers are zero, the enable is 0, and `match_out` and `chain_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| bus_write | input | 1 | Direction, 1 = write |
| bus_size | input | 2 | Transfer size |
| bus_is_data | input | 1 | 0 = instruction fetch, 1 = data access |
| bus_priv | input | 1 | 0 = user, 1 = non-user |
| dbg_ext | input | 1 | External debug input |
| chain_in | input | 1 | Chain input from another unit |
| match_out | output | 1 | Registered one-cycle match pulse |
| chain_out | output | 1 | Same-cycle match for chaining |

## Verification
The assertions check, on every cycle, that a cleared enable or an invalid bus cycle is never followed by a pulse, that register writes land in the selected register, and that control mask writes and unused select codes leave the other registers unchanged. Only the bench scenarios can show the comparison itself. These scenarios cover partially masked addresses, address-only watching, each control bit in its position with its polarity, the reserved linking bit, the chain output's same-cycle timing and back-to-back pulses.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int CTRL_CMP_W = 8;
  localparam int CTRL_VAL_W = 9;

  localparam int CB_WRITE  = 0;
  localparam int CB_SIZE   = 1;
  localparam int CB_KIND   = 3;
  localparam int CB_PRIV   = 4;
  localparam int CB_DBG    = 5;
  localparam int CB_CHAIN  = 6;
  localparam int CB_LINK   = 7;
  localparam int CB_ENABLE = 8;

  typedef enum logic [2:0] {
    SEL_ADDR_VAL  = 3'd0,
    SEL_ADDR_MASK = 3'd1,
    SEL_DATA_VAL  = 3'd2,
    SEL_DATA_MASK = 3'd3,
    SEL_CTRL_VAL  = 3'd4,
    SEL_CTRL_MASK = 3'd5
  } wpt_sel_e;
endpackage

// File: rtl/wpt_regfile.sv
module wpt_regfile
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [2:0]            sel,
  input  logic [CFG_W-1:0]      wdata,
  output logic [ADDR_W-1:0]     addr_val,
  output logic [ADDR_W-1:0]     addr_mask,
  output logic [DATA_W-1:0]     data_val,
  output logic [DATA_W-1:0]     data_mask,
  output logic [CTRL_VAL_W-1:0] ctrl_val,
  output logic [CTRL_CMP_W-1:0] ctrl_mask
);
  logic en_av, en_am, en_dv, en_dm, en_cv, en_cm;

  always_comb begin
    en_av = we && (sel == SEL_ADDR_VAL);
    en_am = we && (sel == SEL_ADDR_MASK);
    en_dv = we && (sel == SEL_DATA_VAL);
    en_dm = we && (sel == SEL_DATA_MASK);
    en_cv = we && (sel == SEL_CTRL_VAL);
    en_cm = we && (sel == SEL_CTRL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_val  <= '0;
      addr_mask <= '0;
      data_val  <= '0;
      data_mask <= '0;
      ctrl_val  <= '0;
      ctrl_mask <= '0;
    end else begin
      if (en_av) addr_val  <= wdata[ADDR_W-1:0];
      if (en_am) addr_mask <= wdata[ADDR_W-1:0];
      if (en_dv) data_val  <= wdata[DATA_W-1:0];
      if (en_dm) data_mask <= wdata[DATA_W-1:0];
      if (en_cv) ctrl_val  <= wdata[CTRL_VAL_W-1:0];
      if (en_cm) ctrl_mask <= wdata[CTRL_CMP_W-1:0];
    end
  end

  // R8
  addr_val_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 3'd0) |=> (addr_val == $past(wdata[ADDR_W-1:0])));

  // R5
  ctrl_mask_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 3'd5) |=> $stable(ctrl_val));

  // R8
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel[2:1] == 2'b11) |=> ($stable(addr_val) && $stable(addr_mask) &&
      $stable(data_val) && $stable(data_mask) && $stable(ctrl_val) && $stable(ctrl_mask)));
endmodule

// File: rtl/wpt_field_cmp.sv
module wpt_field_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] probe,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = mask[i] | ~(value[i] ^ probe[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/wpt_match_stage.sv
module wpt_match_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic match_q
);
  logic match_d;

  always_comb match_d = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end
endmodule

// File: rtl/bus_watchpoint.sv
module bus_watchpoint
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [((ADDR_W > DATA_W) ? ADDR_W : DATA_W)-1:0] cfg_wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic              bus_is_data,
  input  logic              bus_priv,
  input  logic              dbg_ext,
  input  logic              chain_in,
  output logic              match_out,
  output logic              chain_out
);
  localparam int CFG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [ADDR_W-1:0]     addr_val, addr_mask;
  logic [DATA_W-1:0]     data_val, data_mask;
  logic [CTRL_VAL_W-1:0] ctrl_val;
  logic [CTRL_CMP_W-1:0] ctrl_mask;
  logic [CTRL_CMP_W-1:0] ctrl_probe;
  logic                  addr_hit, data_hit, ctrl_hit, unit_hit;

  wpt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .addr_val(addr_val), .addr_mask(addr_mask), .data_val(data_val),
    .data_mask(data_mask), .ctrl_val(ctrl_val), .ctrl_mask(ctrl_mask)
  );

  always_comb begin
    ctrl_probe                   = '0;
    ctrl_probe[CB_WRITE]         = bus_write;
    ctrl_probe[CB_SIZE+1:CB_SIZE] = bus_size;
    ctrl_probe[CB_KIND]          = bus_is_data;
    ctrl_probe[CB_PRIV]          = bus_priv;
    ctrl_probe[CB_DBG]           = dbg_ext;
    ctrl_probe[CB_CHAIN]         = chain_in;
    ctrl_probe[CB_LINK]          = 1'b0;
  end

  wpt_field_cmp #(.W(ADDR_W)) i_addr_cmp (
    .value(addr_val), .mask(addr_mask), .probe(bus_addr), .hit(addr_hit));
  wpt_field_cmp #(.W(DATA_W)) i_data_cmp (
    .value(data_val), .mask(data_mask), .probe(bus_data), .hit(data_hit));
  wpt_field_cmp #(.W(CTRL_CMP_W)) i_ctrl_cmp (
    .value(ctrl_val[CTRL_CMP_W-1:0]), .mask(ctrl_mask), .probe(ctrl_probe), .hit(ctrl_hit));

  assign unit_hit  = bus_valid & ctrl_val[CB_ENABLE] & addr_hit & data_hit & ctrl_hit;
  assign chain_out = unit_hit;

  wpt_match_stage i_match (
    .clk(clk), .rst_n(rst_sync_n), .hit(unit_hit), .match_q(match_out));

  // R5
  disabled_no_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_val[CB_ENABLE] |=> !match_out);

  // R6
  invalid_no_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_valid |=> !match_out);
endmodule

// File: tb/test_bus_watchpoint.sv
module test_bus_watchpoint;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = '0;
  logic        bus_is_data = 1'b0, bus_priv = 1'b0, dbg_ext = 1'b0, chain_in = 1'b0;
  logic        match_out, chain_out;

  always #4 clk = ~clk;

  bus_watchpoint i_bus_watchpoint (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_write(bus_write),
    .bus_size(bus_size), .bus_is_data(bus_is_data), .bus_priv(bus_priv),
    .dbg_ext(dbg_ext), .chain_in(chain_in), .match_out(match_out), .chain_out(chain_out));

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb_q[$];

  logic [31:0] sh_av, sh_am, sh_dv, sh_dm;
  logic [8:0]  sh_cv;
  logic [7:0]  sh_cm;

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(input bit v, input logic [31:0] a, input logic [31:0] d,
                                   input logic [7:0] c);
    logic [31:0] am, dm;
    logic [7:0]  cm;
    am = ~sh_am & (a ^ sh_av);
    dm = ~sh_dm & (d ^ sh_dv);
    cm = ~sh_cm & (c ^ sh_cv[7:0]);
    return v && sh_cv[8] && (am == 0) && (dm == 0) && (cm == 0);
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    bus_valid = 1'b0; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    case (sel)
      3'd0: sh_av = val;
      3'd1: sh_am = val;
      3'd2: sh_dv = val;
      3'd3: sh_dm = val;
      3'd4: sh_cv = val[8:0];
      3'd5: sh_cm = val[7:0];
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: one bus cycle, push expected registered result
  task automatic bus_cycle(input string tag, input bit v, input logic [31:0] a,
                           input logic [31:0] d, input bit wr, input logic [1:0] sz,
                           input bit kind, input bit priv, input bit dbg, input bit chn);
    bit e;
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; bus_write = wr; bus_size = sz;
    bus_is_data = kind; bus_priv = priv; dbg_ext = dbg; chain_in = chn;
    e = model_hit(v, a, d, {1'b0, chn, dbg, priv, kind, sz, wr});
    #1;
    check({tag, " R7 chain_out"}, chain_out, e);
    sb_q.push_back('{exp: e, tag: tag});
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check({it.tag, " match_out"}, match_out, it.exp);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    sh_av = '0; sh_am = '0; sh_dv = '0; sh_dm = '0; sh_cv = '0; sh_cm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R9 reset match_out", match_out, 1'b0);
    check("R9 reset chain_out", chain_out, 1'b0);
    bus_cycle("R9 R5 zero regs, enable off", 1, 32'h0, 32'h0, 0, 2'b00, 0, 0, 0, 0);

    // all masks open, enable on
    cfg_write(3'd1, 32'hFFFF_FFFF);
    cfg_write(3'd3, 32'hFFFF_FFFF);
    cfg_write(3'd5, 32'h0000_00FF);
    cfg_write(3'd4, 32'h0000_0100);
    bus_cycle("R1 all masked", 1, 32'hDEAD_BEEF, 32'h1234_5678, 1, 2'b11, 1, 1, 1, 1);
    cfg_write(3'd6, 32'h0000_0000);
    cfg_write(3'd7, 32'h0000_0000);
    bus_cycle("R8 unused selects ignored", 1, 32'h0, 32'h0, 0, 2'b00, 0, 0, 0, 0);

    // partially masked address, address-only
    cfg_write(3'd0, 32'h1000_0040);
    cfg_write(3'd1, 32'h0000_000F);
    bus_cycle("R1 low nibble masked", 1, 32'h1000_004C, 32'hAAAA_5555, 0, 2'b10, 1, 0, 0, 0);
    bus_cycle("R2 bit4 differs", 1, 32'h1000_0050, 32'h0, 0, 2'b10, 1, 0, 0, 0);
    bus_cycle("R2 top bit differs", 1, 32'h9000_0040, 32'h0, 0, 2'b10, 1, 0, 0, 0);
    bus_cycle("R3 data ignored", 1, 32'h1000_0040, 32'hFFFF_0000, 1, 2'b00, 0, 1, 1, 1);

    // data compare active
    cfg_write(3'd2, 32'hCAFE_0000);
    cfg_write(3'd3, 32'h0000_FFFF);
    bus_cycle("R2 data upper equal", 1, 32'h1000_0041, 32'hCAFE_1234, 0, 2'b00, 1, 0, 0, 0);
    bus_cycle("R2 data upper differs", 1, 32'h1000_0041, 32'hCAFF_1234, 0, 2'b00, 1, 0, 0, 0);

    // control fields fully compared
    cfg_write(3'd1, 32'hFFFF_FFFF);
    cfg_write(3'd3, 32'hFFFF_FFFF);
    cfg_write(3'd5, 32'h0000_0000);
    cfg_write(3'd4, 32'h0000_010D); // enable, write, word, data, user
    bus_cycle("R4 exact control", 1, 32'h0, 32'h0, 1, 2'b10, 1, 0, 0, 0);
    bus_cycle("R4 read vs write", 1, 32'h0, 32'h0, 0, 2'b10, 1, 0, 0, 0);
    bus_cycle("R4 halfword vs word", 1, 32'h0, 32'h0, 1, 2'b01, 1, 0, 0, 0);
    bus_cycle("R4 fetch vs data", 1, 32'h0, 32'h0, 1, 2'b10, 0, 0, 0, 0);
    bus_cycle("R4 non-user vs user", 1, 32'h0, 32'h0, 1, 2'b10, 1, 1, 0, 0);
    bus_cycle("R4 dbg_ext set", 1, 32'h0, 32'h0, 1, 2'b10, 1, 0, 1, 0);
    bus_cycle("R4 chain_in set", 1, 32'h0, 32'h0, 1, 2'b10, 1, 0, 0, 1);
    cfg_write(3'd4, 32'h0000_0178); // enable, data, non-user, dbg, chain, byte read
    bus_cycle("R4 dbg and chain wanted", 1, 32'h0, 32'h0, 0, 2'b00, 1, 1, 1, 1);
    cfg_write(3'd4, 32'h0000_0180); // link bit set, compared with 0
    bus_cycle("R4 link bit never matches", 1, 32'h0, 32'h0, 0, 2'b00, 0, 0, 0, 0);
    cfg_write(3'd5, 32'h0000_0080);
    bus_cycle("R4 link bit masked", 1, 32'h0, 32'h0, 0, 2'b00, 0, 0, 0, 0);

    // enable has no mask
    cfg_write(3'd5, 32'h0000_01FF);
    bus_cycle("R5 mask bit8 write keeps enable", 1, 32'h0, 32'h0, 1, 2'b11, 1, 1, 1, 1);
    cfg_write(3'd4, 32'h0000_00FF);
    bus_cycle("R5 enable cleared", 1, 32'h0, 32'h0, 1, 2'b11, 1, 1, 1, 1);

    // pulse timing
    cfg_write(3'd4, 32'h0000_0100);
    bus_cycle("R6 back-to-back first", 1, 32'h5, 32'h6, 0, 2'b00, 0, 0, 0, 0);
    bus_cycle("R6 back-to-back second", 1, 32'h7, 32'h8, 1, 2'b01, 1, 0, 0, 0);
    bus_cycle("R6 invalid cycle", 0, 32'h5, 32'h6, 0, 2'b00, 0, 0, 0, 0);
    bus_cycle("R6 single pulse", 1, 32'h9, 32'h0, 0, 2'b00, 0, 0, 0, 0);
    bus_cycle("R6 pulse ends", 0, 32'h0, 32'h0, 0, 2'b00, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule